// File: doc/BRIEF.md
# Inter-processor interrupt command unit

This block gives a processor a pair of memory-mapped command registers for sending an interrupt message to other processors. Software first writes the destination word, which only stores the target processor number. It then writes the command word, which holds the vector, the delivery mode, a level assert/deassert flag and a destination shorthand. That write launches one message on a valid/ready output. The payload is captured at launch, and the shorthand is already decoded into "deliver to self" and "deliver to all others" flags.

While a message waits for acceptance, a busy bit in the command word reads as 1. Software polls this bit and issues the next command only after it clears. Command writes made while busy are dropped.

A fixed-mode command with a vector below a configurable minimum is refused and flagged. A write to an address the block does not decode is also flagged. Both errors gather in an accumulator. Software sees them only after a write to the error register, which moves the accumulated bits into the readable copy and clears the accumulator.

Top module: `ipi_cmd_unit`

## Requirements
- R1: After reset no message is offered, and the command word, destination word and error register all read as zero.
- R2: A write to the destination word (offset 0x310) stores bits 31:24 as the target number, reads back as exactly those bits with the rest zero, and never starts a message.
- R3: A write to the command word (offset 0x300) while idle, with a legal vector, raises msg_valid on the next cycle. The message carries vector bits 7:0, mode bits 10:8 and level bit 14 of that write. The command word reads back bits 19:18, 14, 10:8 and 7:0 as last accepted.
- R4: Command bits 19:18 select the target. 00 sends to the stored target number (msg_self=0, msg_bcast=0). 01 sends to self only (msg_self=1, msg_bcast=0, msg_dest=0). 10 sends to all including self (both flags 1, msg_dest=0). 11 sends to all others (msg_self=0, msg_bcast=1, msg_dest=0).
- R5: Command bit 12 reads 1 from the cycle after a launch until the cycle after msg_valid and msg_ready are both high, and msg_valid equals that bit.
- R6: While a message waits, its payload holds steady. A destination write during that time changes the destination word readback but not the message in flight.
- R7: A command write while busy is ignored. It starts no second message and leaves the command readback unchanged.
- R8: A command with mode 000 and a vector below MIN_VEC (16 by default) sends nothing, leaves busy at 0 and sets error bit 5. Vector 16 in mode 000, and any vector in another mode, is sent. The refused command's fields still show in the command readback.
- R9: A write to any address other than the three registers sets error bit 7.
- R10: The error register (offset 0x280) reads a latched copy in bits 7:0, with all other bits zero. A write to it, whatever the data, copies the accumulator into that copy and clears the accumulator. Errors raised after the last such write do not show until the next one.
- R11: Command bits 17:16, the remote-read status, always read 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 32 | Read data (combinational) |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message accepted when high with msg_valid |
| msg_dest | output | 8 | Target number, zero when a shorthand is used |
| msg_self | output | 1 | Deliver to the sending processor |
| msg_bcast | output | 1 | Deliver to all other processors |
| msg_vector | output | 8 | Interrupt vector |
| msg_mode | output | 3 | Delivery mode |
| msg_level | output | 1 | 1 assert, 0 deassert |

## Verification
The bench builds the unit with its default parameters: offsets 0x300, 0x310 and 0x280, a 12-bit address and a minimum fixed vector of 16. With these values, vectors 15 and 16 form the exact edge of the legality test, and address 0x040 lies outside every decoded register. The acceptance side stalls on a repeating pattern and can also be held off. This keeps a message waiting long enough for busy-time writes to land against it.

// File: rtl/ipi_cmd_unit.sv
module ipi_cmd_unit #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] OFS_LO  = 'h300,
  parameter logic [ADDR_W-1:0] OFS_HI  = 'h310,
  parameter logic [ADDR_W-1:0] OFS_ERR = 'h280,
  parameter int MIN_VEC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [7:0]        msg_dest,
  output logic              msg_self,
  output logic              msg_bcast,
  output logic [7:0]        msg_vector,
  output logic [2:0]        msg_mode,
  output logic              msg_level
);
  logic [7:0] dest_r, vec_r, err_acc, err_rd;
  logic [2:0] mode_r;
  logic [1:0] sh_r;
  logic       lvl_r, busy;

  wire hit_lo  = wr_en && wr_addr == OFS_LO;
  wire hit_hi  = wr_en && wr_addr == OFS_HI;
  wire hit_err = wr_en && wr_addr == OFS_ERR;
  wire hit_bad = wr_en && !(hit_lo || hit_hi || hit_err);
  wire accept  = hit_lo && !busy;
  wire bad_vec = wr_data[10:8] == 3'b000 && wr_data[7:0] < 8'(MIN_VEC);
  wire launch  = accept && !bad_vec;
  wire [1:0] sh = wr_data[19:18];
  wire [7:0] new_err = {hit_bad, 1'b0, accept && bad_vec, 5'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dest_r <= '0; vec_r <= '0; mode_r <= '0; sh_r <= '0; lvl_r <= 1'b0;
      busy <= 1'b0; err_acc <= '0; err_rd <= '0;
      msg_dest <= '0; msg_self <= 1'b0; msg_bcast <= 1'b0;
      msg_vector <= '0; msg_mode <= '0; msg_level <= 1'b0;
    end else begin
      if (hit_hi) dest_r <= wr_data[31:24];
      if (accept) begin
        vec_r  <= wr_data[7:0];
        mode_r <= wr_data[10:8];
        lvl_r  <= wr_data[14];
        sh_r   <= sh;
      end
      if (launch) begin
        busy       <= 1'b1;
        msg_dest   <= (sh == 2'b00) ? dest_r : 8'h00;
        msg_self   <= (sh == 2'b01) || (sh == 2'b10);
        msg_bcast  <= sh[1];
        msg_vector <= wr_data[7:0];
        msg_mode   <= wr_data[10:8];
        msg_level  <= wr_data[14];
      end else if (busy && msg_ready) begin
        busy <= 1'b0;
      end
      if (hit_err) begin
        err_rd  <= err_acc;
        err_acc <= new_err;
      end else begin
        err_acc <= err_acc | new_err;
      end
    end
  end

  assign msg_valid = busy;

  always_comb begin
    if (rd_addr == OFS_LO)
      rd_data = {12'b0, sh_r, 2'b00, 1'b0, lvl_r, 1'b0, busy, 1'b0, mode_r, vec_r};
    else if (rd_addr == OFS_HI)
      rd_data = {dest_r, 24'b0};
    else if (rd_addr == OFS_ERR)
      rd_data = {24'b0, err_rd};
    else
      rd_data = '0;
  end
endmodule

// File: rtl/ipi_cmd_unit_chk.sv
module ipi_cmd_unit_chk #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] OFS_LO = 'h300,
  parameter int MIN_VEC = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [31:0]       rd_data,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [7:0]        msg_dest,
  input logic              msg_self,
  input logic              msg_bcast,
  input logic [7:0]        msg_vector,
  input logic [2:0]        msg_mode,
  input logic              msg_level
);
  wire lo_wr = wr_en && wr_addr == OFS_LO;
  wire low_vec = wr_data[10:8] == 3'b000 && wr_data[7:0] < 8'(MIN_VEC);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_dest) && $stable(msg_vector)
      && $stable(msg_self) && $stable(msg_bcast) && $stable(msg_mode) && $stable(msg_level));

  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready |=> !msg_valid);

  assert_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr && !msg_valid && !low_vec |=> msg_valid);

  assert_refuse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr && !msg_valid && low_vec |=> !msg_valid);

  assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid && !lo_wr |=> !msg_valid);

  assert_busybit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr == OFS_LO |-> rd_data[12] == msg_valid);

  assert_rrstat_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr == OFS_LO |-> rd_data[17:16] == 2'b00);
endmodule

bind ipi_cmd_unit ipi_cmd_unit_chk #(.ADDR_W(ADDR_W), .OFS_LO(OFS_LO), .MIN_VEC(MIN_VEC)) u_chk (.*);

// File: tb/tb_ipi_cmd_unit.sv
module tb_ipi_cmd_unit;
  localparam logic [11:0] LO = 12'h300, HI = 12'h310, ER = 12'h280;
  logic clk = 0, rst_n = 0, wr_en = 0, msg_ready = 0;
  logic [11:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic msg_valid, msg_self, msg_bcast, msg_level;
  logic [7:0] msg_dest, msg_vector;
  logic [2:0] msg_mode;

  ipi_cmd_unit dut (.*);

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0, rdy_hold = 0;
  logic [21:0] expq[$];
  logic [1:0] cyc = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic rdchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d); chk(tag, d, exp);
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int i = 0; i < 50; i++) begin
      rd(LO, d);
      if (!d[12]) return;
      @(posedge clk); #1;
    end
    chk("R5 busy never cleared", 1, 0);
  endtask

  task automatic push(input logic [7:0] id, input logic [31:0] c);
    logic [1:0] s;
    s = c[19:18];
    expq.push_back({(s == 2'b00) ? id : 8'h00, s == 2'b01 || s == 2'b10, s[1],
                    c[7:0], c[10:8], c[14]});
  endtask

  task automatic send(input string tag, input logic [7:0] id, input logic [31:0] c);
    logic [31:0] d;
    wr(HI, {id, 24'h0});
    wr(LO, c);
    push(id, c);
    rd(LO, d);
    chk({tag, " R5 busy set"}, d[12], 1);
    wait_idle();
    rdchk({tag, " R3 readback"}, LO, c & 32'h000C_47FF);
  endtask

  always @(posedge clk) begin
    #1;
    cyc <= cyc + 1;
    msg_ready = !rdy_hold && cyc != 2'b01;
  end

  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      if (expq.size() == 0) begin
        chk("R7 unexpected message", {msg_dest, msg_vector}, 0);
      end else begin
        logic [21:0] e;
        e = expq.pop_front();
        chk("R4 message payload",
            {10'b0, msg_dest, msg_self, msg_bcast, msg_vector, msg_mode, msg_level}, {10'b0, e});
      end
    end
  end

  initial begin
    for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rdchk("R1 cmd word", LO, 0);
    rdchk("R1 dest word", HI, 0);
    rdchk("R1 error reg", ER, 0);
    chk("R1 valid", msg_valid, 0);

    wr(HI, 32'hA500_0123);
    rdchk("R2 dest readback", HI, 32'hA500_0000);
    repeat (2) @(posedge clk); #1;
    chk("R2 no launch", msg_valid, 0);

    send("sh00", 8'h5C, 32'h0000_4030);
    send("sh01", 8'h77, 32'h0004_0010);
    send("sh10", 8'h12, 32'h0008_450F);
    send("sh11", 8'h34, 32'h000C_06FF);
    rdchk("R11 rr status", LO, 32'h000C_06FF);

    rdy_hold = 1;
    wr(HI, 32'h1100_0000);
    wr(LO, 32'h0000_0040);
    push(8'h11, 32'h0000_0040);
    wr(HI, 32'h2200_0000);
    wr(LO, 32'h0004_0050);
    rdchk("R7 ignored while busy", LO, 32'h0000_1040);
    rdchk("R6 dest word updates", HI, 32'h2200_0000);
    chk("R6 in-flight dest", msg_dest, 8'h11);
    rdy_hold = 0;
    wait_idle();
    repeat (3) @(posedge clk); #1;
    chk("R7 single message", msg_valid, 0);

    wr(LO, 32'h0000_000F);
    rd(LO, d);
    chk("R8 no busy", d[12], 0);
    chk("R8 fields shown", d, 32'h0000_000F);
    repeat (3) @(posedge clk); #1;
    chk("R8 not sent", msg_valid, 0);
    rdchk("R10 not yet latched", ER, 0);
    wr(ER, 32'hFFFF_FFFF);
    rdchk("R8 error bit 5", ER, 32'h20);

    wr(12'h040, 32'h1);
    wr(ER, 0);
    rdchk("R9 error bit 7", ER, 32'h80);
    wr(ER, 0);
    rdchk("R10 cleared", ER, 0);

    repeat (5) @(posedge clk); #1;
    chk("R3 all messages seen", expq.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule